// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block brings up a target FPGA in slave-serial mode straight out of a bit-serial flash memory. On a start pulse it strobes the flash to begin a read at the page that holds the image. It then holds the target's active-low program line down for a fixed number of cycles and releases it. It waits for the target to raise its init line, and keeps the configuration clock low for a settling interval of about 100 µs.

The block then runs a loop, one bit per pass. It clocks one bit out of the flash, presents it on the target's data input and gives the target one configuration clock pulse. The loop keeps no length count. Storage is padded with all-ones after the real image, so the loop simply runs until the target raises DONE. A fall of init while bits are moving means the target rejected the image's CRC, and the run is aborted with an error. Two timeouts guard against a target that never leaves reset and one that never finishes. Every result flag stays set until the next start.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the block is idle. `busy`=0, `tgt_prog_n`=1, `tgt_cclk`=0, `flash_sck`=0, `flash_read_go`=0 and all four result flags are 0.
- R2: A `start` pulse while idle produces exactly one single-cycle `flash_read_go` strobe. `tgt_prog_n` falls in the cycle right after that strobe.
- R3: `tgt_prog_n` stays low for exactly PROG_LOW_CYC clock cycles and is then released high.
- R4: After release the block waits for synchronised `tgt_init`=1. If it is not seen within INIT_WAIT_CYC cycles, `init_timeout` is set, the run ends and no CCLK pulse is issued.
- R5: After `tgt_init` is seen high, `tgt_cclk` stays low and no `flash_sck` pulse starts for at least SETTLE_CYC = CLK_HZ/10000 cycles (100 µs).
- R6: Each bit is one `flash_sck` pulse, then `tgt_din` is set to the sampled `flash_miso`, then one `tgt_cclk` pulse. `flash_sck` and `tgt_cclk` are never high together, and `tgt_din` is stable while `tgt_cclk` is high.
- R7: The target receives the flash bit stream in the same order, starting from the first bit after the read strobe.
- R8: The block samples synchronised `tgt_done` at the end of each CCLK low phase. If it is high, `done_ok` is set and `busy` drops. With CCLK_HALF_CYC > SYNC_STAGES, the pulse that raised DONE is the last one issued.
- R9: If synchronised `tgt_init` goes from 1 to 0 during the bit loop, `crc_error` is set, both clocks return low and the run ends.
- R10: If MAX_BITS CCLK pulses have been issued without DONE, `shift_timeout` is set and the run ends after exactly MAX_BITS pulses.
- R11: Result flags hold while idle until the next `start`, which clears them. At most one flag is set. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run (idle only) |
| flash_read_go | output | 1 | One-cycle strobe: flash starts reading at the image page |
| flash_sck | output | 1 | Flash serial clock |
| flash_miso | input | 1 | Flash serial data out |
| tgt_prog_n | output | 1 | Target program line, active low |
| tgt_init | input | 1 | Target init line |
| tgt_done | input | 1 | Target done line |
| tgt_cclk | output | 1 | Target configuration clock |
| tgt_din | output | 1 | Target serial configuration data |
| busy | output | 1 | Run in progress |
| done_ok | output | 1 | Last run finished with DONE high |
| crc_error | output | 1 | Last run saw init fall during loading |
| init_timeout | output | 1 | Last run never saw init rise |
| shift_timeout | output | 1 | Last run hit MAX_BITS without DONE |

## Verification
The hardest cases to reach from the ports are an init fall in the middle of the bit loop and a target that never finishes. Each needs a target that misbehaves at a chosen bit. The bench uses a behavioural target that counts received CCLK pulses and, depending on the vector's mode, raises DONE after the image length, drops init after a chosen bit, never raises init, or never raises DONE. A behavioural flash serves a known pattern padded with ones, so every received bit can be compared against the stream.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_OPEN,
        PH_PROG,
        PH_WAIT_INIT,
        PH_SETTLE,
        PH_FETCH_HI,
        PH_FETCH_LO,
        PH_CCLK_HI,
        PH_CCLK_LO
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   read_go;
        logic   prog_n;
        logic   sck;
        logic   cclk;
        logic   din;
        logic   init_prev;
        logic   ok;
        logic   crc;
        logic   init_to;
        logic   shift_to;
    } seq_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgld_pin_sync.sv
module cfgld_pin_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_phase_timer.sv
module cfgld_phase_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // running timer steps down by one each cycle
    p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cfgld_bit_guard.sv
module cfgld_bit_guard #(
    parameter int unsigned MAX_BITS = 1024,
    localparam int unsigned CW = $clog2(MAX_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic full
);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                               cnt_d = '0;
        else if (tick && cnt_q != CW'(MAX_BITS)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign full = (cnt_q == CW'(MAX_BITS));

    p_guard_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_BITS));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgld_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned PROG_LOW_CYC  = 8,
    parameter int unsigned INIT_WAIT_CYC = 2_000_000,
    parameter int unsigned SCK_HALF_CYC  = 2,
    parameter int unsigned CCLK_HALF_CYC = 3,
    parameter int unsigned MAX_BITS      = 4_000_000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic flash_read_go,
    output logic flash_sck,
    input  logic flash_miso,
    output logic tgt_prog_n,
    input  logic tgt_init,
    input  logic tgt_done,
    output logic tgt_cclk,
    output logic tgt_din,
    output logic busy,
    output logic done_ok,
    output logic crc_error,
    output logic init_timeout,
    output logic shift_timeout
);
    localparam int unsigned SETTLE_CYC = (CLK_HZ / 10000 == 0) ? 1 : CLK_HZ / 10000;
    localparam int unsigned TMR_MAX = max2(max2(max2(SETTLE_CYC, INIT_WAIT_CYC),
                                                max2(PROG_LOW_CYC, SCK_HALF_CYC)),
                                           CCLK_HALF_CYC);
    localparam int unsigned TW = $clog2(TMR_MAX + 1);

    seq_t q, d;
    logic init_s, done_s, tmr_zero, tmr_load, g_clr, g_tick, g_full, in_shift;
    logic [TW-1:0] tmr_val;

    // PROG_LOW_CYC should exceed SYNC_STAGES so the init sync sees the target's reset
    cfgld_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_init (
        .clk(clk), .rst_n(rst_n), .d(tgt_init), .q(init_s));
    cfgld_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst_n(rst_n), .d(tgt_done), .q(done_s));
    cfgld_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));
    cfgld_bit_guard #(.MAX_BITS(MAX_BITS)) u_guard (
        .clk(clk), .rst_n(rst_n), .clr(g_clr), .tick(g_tick), .full(g_full));

    assign in_shift = (q.phase == PH_FETCH_HI) || (q.phase == PH_FETCH_LO) ||
                      (q.phase == PH_CCLK_HI)  || (q.phase == PH_CCLK_LO);

    always_comb begin
        d         = q;
        d.read_go = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        g_clr     = 1'b0;
        g_tick    = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase    = PH_OPEN;
                    d.read_go  = 1'b1;
                    d.ok       = 1'b0;
                    d.crc      = 1'b0;
                    d.init_to  = 1'b0;
                    d.shift_to = 1'b0;
                    g_clr      = 1'b1;
                end
            end
            PH_OPEN: begin
                d.prog_n = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = TW'(PROG_LOW_CYC - 1);
                d.phase  = PH_PROG;
            end
            PH_PROG: begin
                if (tmr_zero) begin
                    d.prog_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(INIT_WAIT_CYC - 1);
                    d.phase  = PH_WAIT_INIT;
                end
            end
            PH_WAIT_INIT: begin
                if (init_s) begin
                    d.init_prev = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(SETTLE_CYC - 1);
                    d.phase     = PH_SETTLE;
                end else if (tmr_zero) begin
                    d.init_to = 1'b1;
                    d.phase   = PH_IDLE;
                end
            end
            PH_SETTLE: begin
                d.init_prev = init_s;
                if (tmr_zero) begin
                    d.sck    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SCK_HALF_CYC - 1);
                    d.phase  = PH_FETCH_HI;
                end
            end
            PH_FETCH_HI: begin
                if (tmr_zero) begin
                    d.din    = flash_miso;
                    d.sck    = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SCK_HALF_CYC - 1);
                    d.phase  = PH_FETCH_LO;
                end
            end
            PH_FETCH_LO: begin
                if (tmr_zero) begin
                    d.cclk   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CCLK_HALF_CYC - 1);
                    d.phase  = PH_CCLK_HI;
                end
            end
            PH_CCLK_HI: begin
                if (tmr_zero) begin
                    d.cclk   = 1'b0;
                    g_tick   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CCLK_HALF_CYC - 1);
                    d.phase  = PH_CCLK_LO;
                end
            end
            PH_CCLK_LO: begin
                if (tmr_zero) begin
                    if (done_s) begin
                        d.ok    = 1'b1;
                        d.phase = PH_IDLE;
                    end else if (g_full) begin
                        d.shift_to = 1'b1;
                        d.phase    = PH_IDLE;
                    end else begin
                        d.sck    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SCK_HALF_CYC - 1);
                        d.phase  = PH_FETCH_HI;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase

        if (in_shift) begin
            d.init_prev = init_s;
            if (q.init_prev && !init_s) begin
                d.crc     = 1'b1;
                d.ok      = 1'b0;
                d.sck     = 1'b0;
                d.cclk    = 1'b0;
                d.phase   = PH_IDLE;
                tmr_load  = 1'b0;
                g_tick    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.phase     <= PH_IDLE;
            q.prog_n    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign flash_read_go = q.read_go;
    assign flash_sck     = q.sck;
    assign tgt_prog_n    = q.prog_n;
    assign tgt_cclk      = q.cclk;
    assign tgt_din       = q.din;
    assign busy          = (q.phase != PH_IDLE);
    assign done_ok       = q.ok;
    assign crc_error     = q.crc;
    assign init_timeout  = q.init_to;
    assign shift_timeout = q.shift_to;

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tgt_prog_n && !tgt_cclk && !flash_sck));
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flash_read_go |=> (!flash_read_go && !tgt_prog_n));
    p_prog_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_prog_n) |-> $past(flash_read_go));
    p_no_cclk_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WAIT_INIT || q.phase == PH_PROG) |-> (!tgt_cclk && !flash_sck));
    p_clk_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_sck && tgt_cclk));
    p_din_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_cclk && $past(tgt_cclk)) |-> $stable(tgt_din));
    p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done_ok, crc_error, init_timeout, shift_timeout}) <= 1);
    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({done_ok, crc_error, init_timeout, shift_timeout}));
    p_crc_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_error) |-> (!busy && !tgt_cclk && !flash_sck));
endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 100_000;
    localparam int SETTLE     = CLK_HZ / 10000;
    localparam int PROG_LOW   = 4;
    localparam int INIT_WAIT  = 50;
    localparam int SCK_HALF   = 1;
    localparam int CCLK_HALF  = 3;
    localparam int MAXB       = 64;
    localparam int SYNC       = 2;
    localparam int INIT_DLY   = 6;

    // mode: 0 good image, 1 init drop after len bits, 2 init never rises, 3 done never rises
    typedef struct packed {
        logic [7:0]  len;
        logic [31:0] pat;
        logic [1:0]  mode;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{8'd40, 32'hA5C3_0F19, 2'd0},
        '{8'd1,  32'h0000_0000, 2'd0},
        '{8'd63, 32'h0000_FFFF, 2'd0},
        '{8'd20, 32'h1234_5678, 2'd1},
        '{8'd10, 32'h0F0F_0F0F, 2'd2},
        '{8'd10, 32'hFFFF_0000, 2'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic flash_read_go, flash_sck, flash_miso, tgt_prog_n, tgt_cclk, tgt_din;
    logic tgt_init, tgt_done, busy, done_ok, crc_error, init_timeout, shift_timeout;

    int total = 0, bad = 0;
    int cur_len = 1;
    logic [31:0] cur_pat = '0;
    int cur_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_loader #(
        .CLK_HZ(CLK_HZ), .PROG_LOW_CYC(PROG_LOW), .INIT_WAIT_CYC(INIT_WAIT),
        .SCK_HALF_CYC(SCK_HALF), .CCLK_HALF_CYC(CCLK_HALF), .MAX_BITS(MAXB),
        .SYNC_STAGES(SYNC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .flash_read_go(flash_read_go),
        .flash_sck(flash_sck), .flash_miso(flash_miso), .tgt_prog_n(tgt_prog_n),
        .tgt_init(tgt_init), .tgt_done(tgt_done), .tgt_cclk(tgt_cclk), .tgt_din(tgt_din),
        .busy(busy), .done_ok(done_ok), .crc_error(crc_error),
        .init_timeout(init_timeout), .shift_timeout(shift_timeout));

    function automatic logic fbit(input int i, input int len, input logic [31:0] pat);
        return (i < len) ? pat[i % 32] : 1'b1;
    endfunction

    // flash and target models
    int ptr = 0, cyc = 0, dly = 0, t_init = 0, rx_n = 0, mism = 0;
    logic sck_prev = 1'b0, init_m = 1'b0, raised = 1'b0;
    assign flash_miso = fbit(ptr, cur_len, cur_pat);
    assign tgt_init   = init_m;
    assign tgt_done   = (cur_mode == 0) && (rx_n >= cur_len);

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        sck_prev <= flash_sck;
        if (flash_read_go) ptr <= 0;
        else if (sck_prev && !flash_sck) ptr <= ptr + 1;
        if (!tgt_prog_n) begin
            init_m <= 1'b0; dly <= 0; raised <= 1'b0;
        end else if (cur_mode == 1 && init_m && rx_n >= cur_len) begin
            init_m <= 1'b0;
        end else if (!raised && cur_mode != 2) begin
            if (dly == INIT_DLY - 1) begin
                init_m <= 1'b1; raised <= 1'b1; t_init <= cyc;
            end else dly <= dly + 1;
        end
    end

    always @(posedge tgt_cclk or negedge tgt_prog_n) begin
        if (!tgt_prog_n) begin
            rx_n <= 0; mism <= 0;
        end else begin
            if (tgt_din !== fbit(rx_n, cur_len, cur_pat)) mism <= mism + 1;
            rx_n <= rx_n + 1;
        end
    end

    // port monitor
    int go_cnt = 0, prog_low = 0, overlap = 0, go_order_err = 0, t_sck = 0;
    logic armed = 1'b0, prev_go = 1'b0, prev_prog = 1'b1;
    always @(negedge clk) begin
        if (flash_read_go) go_cnt <= go_cnt + 1;
        if (!tgt_prog_n) prog_low <= prog_low + 1;
        if (flash_sck && tgt_cclk) overlap <= overlap + 1;
        if (!tgt_prog_n && prev_prog && !prev_go) go_order_err <= go_order_err + 1;
        if (!tgt_prog_n) armed <= 1'b1;
        else if (armed && flash_sck) begin armed <= 1'b0; t_sck <= cyc; end
        prev_go   <= flash_read_go;
        prev_prog <= tgt_prog_n;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk(!busy, "watchdog", int'(busy), 0);
    endtask

    task automatic run(input int len, input logic [31:0] pat, input int mode, input bit extra);
        int go0, pl0, ov0, oe0;
        cur_len = len; cur_pat = pat; cur_mode = mode;
        go0 = go_cnt; pl0 = prog_low; ov0 = overlap; oe0 = go_order_err;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra) begin
            repeat (30) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_idle();
        chk(go_cnt - go0 == 1, "R2 strobe count", go_cnt - go0, 1);
        chk(go_order_err == oe0, "R2 strobe before prog", go_order_err - oe0, 0);
        chk(prog_low - pl0 == PROG_LOW, "R3 prog width", prog_low - pl0, PROG_LOW);
        chk(overlap == ov0, "R6 clock overlap", overlap - ov0, 0);
        chk(mism == 0, "R7 data mismatch", mism, 0);
        case (mode)
            0: begin
                chk(done_ok && !crc_error && !init_timeout && !shift_timeout,
                    "R8 done flag", int'(done_ok), 1);
                chk(rx_n == len, "R8 bits delivered", rx_n, len);
                chk((t_sck - t_init) >= SETTLE && (t_sck - t_init) <= SETTLE + SYNC + 3,
                    "R5 settle gap", t_sck - t_init, SETTLE);
            end
            1: begin
                chk(crc_error && !done_ok, "R9 crc flag", int'(crc_error), 1);
                chk(rx_n >= len && rx_n <= len + 2, "R9 stop point", rx_n, len);
                chk(!tgt_cclk && !flash_sck, "R9 clocks low", int'(tgt_cclk | flash_sck), 0);
            end
            2: begin
                chk(init_timeout && !done_ok, "R4 init timeout", int'(init_timeout), 1);
                chk(rx_n == 0, "R4 no cclk", rx_n, 0);
            end
            default: begin
                chk(shift_timeout && !done_ok, "R10 shift timeout", int'(shift_timeout), 1);
                chk(rx_n == MAXB, "R10 pulse count", rx_n, MAXB);
            end
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && tgt_prog_n && !tgt_cclk && !flash_sck && !flash_read_go,
            "R1 reset pins", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_ok && !crc_error && !init_timeout && !shift_timeout,
            "R1 reset flags", int'(done_ok | crc_error | init_timeout | shift_timeout), 0);

        for (int i = 0; i < NV; i++)
            run(int'(VEC[i].len), VEC[i].pat, int'(VEC[i].mode), 1'b0);

        // R11: flag from last run holds while idle
        repeat (20) @(negedge clk);
        chk(shift_timeout && !busy, "R11 flag hold", int'(shift_timeout), 1);

        // R11: start while busy is ignored, new start clears old flag
        run(40, 32'hC3A5_5A3C, 0, 1'b1);
        chk(!shift_timeout, "R11 flag cleared", int'(shift_timeout), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule